// File: doc/BRIEF.md
# Sequential Control-Word Display Loader

This block is the bus-side front end of a multiplexed LED display controller. A host drives an 8-bit data bus, a mode select and an active-low write strobe. Each completed low pulse on the strobe performs exactly one action. With the mode select high, the action latches a control word. The control word sets the display enable (shutdown when low), the decoder bypass, the decoder flavour (hexadecimal or the alternate digit set) and an "arm" flag. With the mode select low, the action stores the bus byte into the next slot of an eight-byte display store.

Data bytes are accepted only after a control word with the arm flag set. The first byte goes to slot 0 and each later byte to the slot after it. After the eighth byte the store locks, and further data strobes are dropped until a new control word arrives. A single slot therefore cannot be rewritten alone: the whole set of eight is reloaded. A loading flag tells the scan engine to blank the display while a load is in progress. A combinational read port lets the scan engine fetch any slot.

Top module: `seq_display_loader`

## Requirements
- R1: A strobe with mode_sel high loads the control word: bit 4 gives run_en (1 = normal, 0 = shutdown), bit 5 gives raw_mode (1 = segments taken directly, 0 = decoded), bit 6 gives hex_sel (1 = hexadecimal, 0 = alternate digit set) and bit 7 is the arm flag. Bits 0 to 3 have no effect.
- R2: wr_n is synchronized to clk. An action occurs once per low pulse, when wr_n returns high. Its effect is visible after the third rising clk edge that samples wr_n high following a low sample, and not earlier. Outputs change at no other time.
- R3: A control word with bit 7 set moves the store pointer to slot 0. Successive data strobes then store into slots 0, 1, 2 … 7 in order. This also holds when the control word arrives partway through a load.
- R4: After the eighth byte of a load is stored, further data strobes leave every slot and the store outputs unchanged until a new control word is loaded.
- R5: A data strobe with no armed load in progress is ignored. A control word with bit 7 clear changes only the flags: it ends any load in progress and leaves the store untouched.
- R6: loading is high from an arming control word until the eighth byte is stored, or until a non-arming control word arrives.
- R7: Data strobes are stored normally while run_en is low.
- R8: Reset clears all eight slots and sets run_en=1, raw_mode=0, hex_sel=1, loading=0 and store_pulse=0.
- R9: Each accepted data byte produces store_pulse high for exactly one cycle, with store_addr set to the slot and store_data set to the byte. Both hold their values until the next accepted byte.
- R10: rd_data always equals the stored content of slot rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Host data bus (control word or display byte) |
| mode_sel | input | 1 | 1 = control word, 0 = display byte |
| wr_n | input | 1 | Active-low write strobe, asynchronous to clk |
| rd_addr | input | 3 | Scan-side read slot select |
| run_en | output | 1 | 1 = normal operation, 0 = shutdown |
| raw_mode | output | 1 | 1 = decoder bypass |
| hex_sel | output | 1 | 1 = hexadecimal decoding, 0 = alternate digit set |
| loading | output | 1 | Load in progress; display to be blanked |
| store_pulse | output | 1 | One-cycle marker of an accepted byte |
| store_addr | output | 3 | Slot of the last accepted byte |
| store_data | output | 8 | Value of the last accepted byte |
| rd_data | output | 8 | Content of slot rd_addr |

## Verification
The checker watches several properties on every cycle. Store pulses last one cycle and need a preceding strobe and an armed state. Successive store slots step by one. The load ends on the last slot. The flags never move without a detected strobe. Other behaviour is shown only by the bench scenarios, which compare against a behavioural model on every clock. These cover the field decoding with noise in bits 0 to 3, the exact three-edge latency, the contents written and read back, and the dropping of strobes after the eighth byte or without arming. They also cover a restart partway through a load, a non-arming word ending a load, and storing during shutdown.

// File: rtl/loader_pkg.sv
package loader_pkg;
    // Control word field positions; the host decodes these, so they are fixed.
    localparam int CTRL_RUN_BIT = 4;
    localparam int CTRL_RAW_BIT = 5;
    localparam int CTRL_HEX_BIT = 6;
    localparam int CTRL_ARM_BIT = 7;

    typedef struct packed {
        logic run_en;
        logic raw_mode;
        logic hex_sel;
    } disp_flags_t;

    localparam disp_flags_t FLAGS_RESET = '{run_en: 1'b1, raw_mode: 1'b0, hex_sel: 1'b1};
endpackage

// File: rtl/loader_strobe_sync.sv
module loader_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], wr_n};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= '1;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // Low-to-high on the synchronized strobe marks a completed pulse.
    assign rise = st_q.sync[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/loader_seq_ctrl.sv
module loader_seq_ctrl
    import loader_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              mode_sel,
    input  logic [DATA_W-1:0] bus_data,
    output disp_flags_t       flags,
    output logic              loading,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              store_pulse,
    output logic [AW-1:0]     store_addr,
    output logic [DATA_W-1:0] store_data
);
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

    typedef struct packed {
        disp_flags_t       flags;
        logic              armed;
        logic [AW-1:0]     ptr;
        logic              pulse;
        logic [AW-1:0]     paddr;
        logic [DATA_W-1:0] pdata;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        wr_en      = 1'b0;
        if (rise) begin
            if (mode_sel) begin
                st_d.flags.run_en   = bus_data[CTRL_RUN_BIT];
                st_d.flags.raw_mode = bus_data[CTRL_RAW_BIT];
                st_d.flags.hex_sel  = bus_data[CTRL_HEX_BIT];
                st_d.armed          = bus_data[CTRL_ARM_BIT];
                st_d.ptr            = '0;
            end else if (st_q.armed) begin
                wr_en      = 1'b1;
                st_d.pulse = 1'b1;
                st_d.paddr = st_q.ptr;
                st_d.pdata = bus_data;
                st_d.ptr   = st_q.ptr + AW'(1);
                if (st_q.ptr == LAST_SLOT) begin
                    st_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= FLAGS_RESET;
            st_q.armed <= 1'b0;
            st_q.ptr   <= '0;
            st_q.pulse <= 1'b0;
            st_q.paddr <= '0;
            st_q.pdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags       = st_q.flags;
    assign loading     = st_q.armed;
    assign wr_addr     = st_q.ptr;
    assign wr_data     = bus_data;
    assign store_pulse = st_q.pulse;
    assign store_addr  = st_q.paddr;
    assign store_data  = st_q.pdata;
endmodule

// File: rtl/loader_byte_mem.sv
module loader_byte_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_comb begin
            mem_d[i] = mem_q[i];
            if (we && (waddr == AW'(i))) begin
                mem_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/seq_display_loader.sv
module seq_display_loader
    import loader_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              mode_sel,
    input  logic              wr_n,
    input  logic [AW-1:0]     rd_addr,
    output logic              run_en,
    output logic              raw_mode,
    output logic              hex_sel,
    output logic              loading,
    output logic              store_pulse,
    output logic [AW-1:0]     store_addr,
    output logic [DATA_W-1:0] store_data,
    output logic [DATA_W-1:0] rd_data
);
    logic              strobe_rise;
    disp_flags_t       flags;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    loader_strobe_sync #(
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_n (wr_n),
        .rise (strobe_rise)
    );

    loader_seq_ctrl #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (strobe_rise),
        .mode_sel   (mode_sel),
        .bus_data   (bus_data),
        .flags      (flags),
        .loading    (loading),
        .wr_en      (mem_we),
        .wr_addr    (mem_waddr),
        .wr_data    (mem_wdata),
        .store_pulse(store_pulse),
        .store_addr (store_addr),
        .store_data (store_data)
    );

    loader_byte_mem #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) i_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    assign run_en   = flags.run_en;
    assign raw_mode = flags.raw_mode;
    assign hex_sel  = flags.hex_sel;
endmodule

// File: rtl/seq_display_loader_chk.sv
module seq_display_loader_chk #(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strobe_rise,
    input logic          run_en,
    input logic          raw_mode,
    input logic          hex_sel,
    input logic          loading,
    input logic          store_pulse,
    input logic [AW-1:0] store_addr
);
    logic [AW-1:0] last_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_addr_q <= '0;
        end else if (store_pulse) begin
            last_addr_q <= store_addr;
        end
    end

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |=> !store_pulse);

    p_store_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |-> $past(loading));

    p_pulse_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |-> $past(strobe_rise));

    p_lock_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_pulse && store_addr == AW'(DEPTH - 1)) |-> !loading);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (store_pulse && store_addr != '0) |-> (store_addr == AW'(last_addr_q + AW'(1))));

    p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(strobe_rise) |-> $stable({run_en, raw_mode, hex_sel}));
endmodule

bind seq_display_loader seq_display_loader_chk #(
    .DEPTH(DEPTH)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_rise(strobe_rise),
    .run_en     (run_en),
    .raw_mode   (raw_mode),
    .hex_sel    (hex_sel),
    .loading    (loading),
    .store_pulse(store_pulse),
    .store_addr (store_addr)
);

// File: tb/test_seq_display_loader.sv
module test_seq_display_loader;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_data = '0;
    logic       mode_sel = 1'b0;
    logic       wr_n = 1'b1;
    logic [2:0] rd_addr = '0;
    logic       run_en, raw_mode, hex_sel, loading, store_pulse;
    logic [2:0] store_addr;
    logic [7:0] store_data, rd_data;

    int vectors = 0;
    int miscompares = 0;
    bit cmp_en = 1'b0;

    seq_display_loader i_seq_display_loader (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .mode_sel(mode_sel),
        .wr_n(wr_n), .rd_addr(rd_addr), .run_en(run_en), .raw_mode(raw_mode),
        .hex_sel(hex_sel), .loading(loading), .store_pulse(store_pulse),
        .store_addr(store_addr), .store_data(store_data), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int m_mem[DEPTH];
    bit m_run, m_raw, m_hex, m_armed, m_pulse;
    int m_ptr, m_paddr, m_pdata;
    bit wq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_run = 1; m_raw = 0; m_hex = 1; m_armed = 0; m_pulse = 0;
            m_ptr = 0; m_paddr = 0; m_pdata = 0;
            wq = '{1'b1, 1'b1, 1'b1, 1'b1};
        end else begin
            wq.push_front(wr_n);
            if (wq.size() > 4) void'(wq.pop_back());
            m_pulse = 0;
            if (wq[2] && !wq[3]) begin
                if (mode_sel) begin
                    m_run = bus_data[4]; m_raw = bus_data[5];
                    m_hex = bus_data[6]; m_armed = bus_data[7];
                    m_ptr = 0;
                end else if (m_armed) begin
                    m_mem[m_ptr] = bus_data;
                    m_pulse = 1; m_paddr = m_ptr; m_pdata = bus_data;
                    m_ptr = m_ptr + 1;
                    if (m_ptr == DEPTH) begin
                        m_armed = 0;
                        m_ptr = 0;
                    end
                end
            end
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge
    always begin
        @(negedge clk);
        #1;
        if (cmp_en) begin
            cmp("R1 run_en", run_en, m_run);
            cmp("R1 raw_mode", raw_mode, m_raw);
            cmp("R1 hex_sel", hex_sel, m_hex);
            cmp("R6 loading", loading, m_armed);
            cmp("R9 store_pulse", store_pulse, m_pulse);
            cmp("R9 store_addr", store_addr, m_paddr);
            cmp("R9 store_data", store_data, m_pdata);
            cmp("R10 rd_data", rd_data, m_mem[rd_addr]);
        end
    end

    task automatic do_write(input bit m, input logic [7:0] d);
        @(negedge clk);
        mode_sel = m; bus_data = d; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        @(negedge clk);
        rd_addr = 3'(a);
        #2;
        cmp(tag, rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R8 reset state
        cmp("R8 run_en", run_en, 1);
        cmp("R8 raw_mode", raw_mode, 0);
        cmp("R8 hex_sel", hex_sel, 1);
        cmp("R8 loading", loading, 0);
        cmp("R8 store_pulse", store_pulse, 0);
        for (int i = 0; i < DEPTH; i++) rd_chk(i, 0, "R8 slot cleared");
        cmp_en = 1'b1;

        // R2 latency: arm + shutdown + raw + hex, low nibble noise
        @(negedge clk);
        mode_sel = 1'b1; bus_data = 8'hE5; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        #2 cmp("R2 no early effect", run_en, 1);
        @(negedge clk);
        #2 cmp("R2 effect after third edge", run_en, 0);
        cmp("R1 raw bit5", raw_mode, 1);
        cmp("R6 loading raised", loading, 1);
        repeat (2) @(negedge clk);

        // R7: eight bytes during shutdown
        for (int i = 0; i < DEPTH; i++) do_write(1'b0, 8'(8'h11 * i + 3));
        cmp("R4 locked after eighth", loading, 0);
        for (int i = 0; i < DEPTH; i++) rd_chk(i, 8'h11 * i + 3, "R7 R3 stored in order");

        // R4: extra strobes are dropped
        for (int i = 0; i < 3; i++) do_write(1'b0, 8'hAA);
        for (int i = 0; i < DEPTH; i++) rd_chk(i, 8'h11 * i + 3, "R4 store unchanged");

        // R5: non-arming word, then a data strobe
        do_write(1'b1, 8'h50);
        cmp("R1 flags run", run_en, 1);
        cmp("R1 flags hex", hex_sel, 1);
        do_write(1'b0, 8'h77);
        rd_chk(0, 8'h03, "R5 slot0 untouched");
        cmp("R5 no pulse", store_data, 8'h7A);

        // R3 restart partway through a load
        do_write(1'b1, 8'h9F);
        cmp("R1 hex clear, low bits ignored", hex_sel, 0);
        cmp("R1 raw clear", raw_mode, 0);
        for (int i = 0; i < 3; i++) do_write(1'b0, 8'(8'hC0 + i));
        do_write(1'b1, 8'h80);
        for (int i = 0; i < DEPTH; i++) do_write(1'b0, 8'(8'h20 + i));
        for (int i = 0; i < DEPTH; i++) rd_chk(i, 8'h20 + i, "R3 restart order");

        // R5 non-arming word ends a load in progress
        do_write(1'b1, 8'h80);
        do_write(1'b0, 8'h5A);
        do_write(1'b0, 8'h5B);
        do_write(1'b1, 8'h10);
        cmp("R5 load ended", loading, 0);
        do_write(1'b0, 8'h5C);
        rd_chk(2, 8'h22, "R5 slot2 kept");
        rd_chk(1, 8'h5B, "R3 slot1 written");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule